// File: doc/BRIEF.md
# Per-Region Bus Wait Inserter

This block works on the device side of a Z80-style bus. When a bus cycle starts, a region lookup outside this block reports whether the address fell in a configured region. For a hit it also gives that region's wait count, a synchronisation flag and a flag that marks host video-RAM pass-through. The block then holds the active-low WAIT line low for the required number of host T-cycles. This gives the internal memory or device handler time to finish before data must be on the bus.

The block also sends a one-cycle ready-window pulse to the internal data source, marking when its access may begin. With the sync flag clear, the pulse follows the cycle start at once. With the flag set, the pulse waits for the next rising host clock edge, which is T1. This ties the access window to the host clock so it cannot drift. All inputs are single-cycle strobes or levels in the local clock domain. The host clock edge arrives already synchronised as a strobe.

Top module: `wsi_wait_inserter`

## Requirements
- R1: While reset is applied and in the cycle after it, `wait_n` is 1 and `ready_pulse` is 0.
- R2: A `cyc_start` strobe with `region_hit`=1 and an effective count N>0 drives `wait_n` low from the next clock. `wait_n` stays low until the N-th later `host_rise` strobe has been sampled, and is 1 in the clock after that strobe.
- R3: A hit whose effective count is zero leaves `wait_n` at 1.
- R4: When `region_vram`=1, the effective count is `region_waits` + VRAM_EXTRA (default 2), capped at 15. When `region_vram`=0, it is `region_waits`.
- R5: A `cyc_start` with `region_hit`=0 releases WAIT and produces no ready pulse.
- R6: While `bus_granted`=1, `wait_n` is 1 and `ready_pulse` is 0 from the next clock on, and `cyc_start` has no effect.
- R7: With `region_sync`=0, a hit gives `ready_pulse`=1 for exactly the one clock after `cyc_start` is sampled.
- R8: With `region_sync`=1, a hit gives `ready_pulse`=1 for one clock. That clock follows the first `host_rise` sampled after `cyc_start`. There is no pulse before then.
- R9: A `host_rise` in the same clock as `cyc_start` does not decrement the count. A new `cyc_start` reloads the count and window state.
- R10: `region_waits` is a 4-bit field, so a region can request from 0 to 15 extra T-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe: a new bus cycle has begun; the region fields are valid |
| host_rise | input | 1 | One-clock strobe per rising edge of the host clock |
| bus_granted | input | 1 | Bus is granted away to another master |
| region_hit | input | 1 | Address lies in a configured region |
| region_waits | input | 4 | Extra T-cycles requested by the region |
| region_sync | input | 1 | Start the access window on the T1 edge |
| region_vram | input | 1 | Region is host video-RAM pass-through (extra waits) |
| wait_n | output | 1 | Active-low WAIT to the host bus |
| ready_pulse | output | 1 | One-clock pulse opening the internal access window |

## Verification
The assertions assume that `cyc_start` and `host_rise` are single-clock strobes already in the local clock domain. They also assume the region fields are valid in the clock where `cyc_start` is high. The random stimulus draws each strobe freshly every clock, so it can coincide with a start, a grant or another strobe, but it is never stretched. It also mixes hits, misses, zero counts and saturating video-RAM counts. This lets the reload, the same-clock and the grant-clear orderings all occur.

// File: rtl/wsi_pkg.sv
// Shared parameters and helpers for the wait inserter.
// Assumes: wait counts are unsigned and fit in WAIT_W bits.
package wsi_pkg;
    localparam int WAIT_W = 4;
    localparam int WAIT_MAX = (1 << WAIT_W) - 1;
    typedef logic [WAIT_W-1:0] wait_cnt_t;
endpackage

// File: rtl/wsi_count_calc.sv
// Computes the effective wait count of a region: the configured count
// plus an optional video-RAM surcharge, capped at the counter's maximum.
// Assumes: pure combinational, inputs valid alongside the cycle start.
module wsi_count_calc #(
    parameter int CNT_W      = 4,
    parameter int VRAM_EXTRA = 2
) (
    input  logic [CNT_W-1:0] waits,
    input  logic             vram,
    output logic [CNT_W-1:0] eff
);
    localparam int MAXV = (1 << CNT_W) - 1;

    generate
        if (VRAM_EXTRA == 0) begin : g_plain
            // Purpose: no surcharge configured, pass the count through.
            always_comb eff = waits;
        end else begin : g_extra
            logic [CNT_W:0] sum;
            // Purpose: add the surcharge for video RAM and saturate.
            always_comb begin
                sum = {1'b0, waits} + (vram ? (CNT_W+1)'(VRAM_EXTRA) : '0);
                eff = (sum > (CNT_W+1)'(MAXV)) ? CNT_W'(MAXV) : sum[CNT_W-1:0];
            end
        end
    endgenerate

    // Purpose: the surcharge may never reduce the requested count.
    always_comb begin
        AST_EFF_NOT_BELOW: assert (eff >= waits); // R4
    end
endmodule

// File: rtl/wsi_wait_counter.sv
// Holds the remaining T-cycle count of the current bus cycle and reports
// whether WAIT must be held. Loads on start, counts down on host edges.
// Assumes: start and host_rise are one-clock strobes; clear has priority.
module wsi_wait_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic             host_rise,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    // Purpose: load, decrement or clear the remaining wait count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (host_rise && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !busy); // R6
    AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_rise && !start && !clear) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rise && !start && !clear) |=> $stable(cnt)); // R2
    AST_SAME_CLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> (cnt == $past(load_val))); // R9
endmodule

// File: rtl/wsi_window_gen.sv
// Produces the one-clock ready-window pulse for the internal data source,
// either right after the cycle start or on the next host clock rise (T1).
// Assumes: start and host_rise are one-clock strobes; clear has priority.
module wsi_window_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic sync,
    input  logic host_rise,
    output logic ready
);
    logic armed;

    // Purpose: arm on a synchronised start, fire on the following host rise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            armed <= 1'b0;
            ready <= 1'b0;
        end else if (start) begin
            armed <= sync;
            ready <= !sync;
        end else begin
            ready <= armed && host_rise;
            if (host_rise) armed <= 1'b0;
        end
    end

    AST_NOSYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sync && !clear) |=> ready); // R7
    AST_SYNC_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sync) |=> !ready); // R8
    AST_SYNC_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && host_rise && !start && !clear) |=> ready); // R8
endmodule

// File: rtl/wsi_wait_inserter.sv
// Top of the per-region wait inserter. Qualifies each cycle start with the
// region lookup and bus grant, then drives WAIT and the ready window.
// Assumes: region fields are valid in the clock where cyc_start is high;
// host_rise is already synchronised to clk.
module wsi_wait_inserter #(
    parameter int VRAM_EXTRA = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cyc_start,
    input  logic                   host_rise,
    input  logic                   bus_granted,
    input  logic                   region_hit,
    input  wsi_pkg::wait_cnt_t     region_waits,
    input  logic                   region_sync,
    input  logic                   region_vram,
    output logic                   wait_n,
    output logic                   ready_pulse
);
    import wsi_pkg::*;

    wait_cnt_t eff_cnt;
    logic      hit_start;
    logic      any_start;
    logic      busy;

    // Purpose: a start counts only when the bus is ours.
    always_comb begin
        any_start = cyc_start && !bus_granted;
        hit_start = any_start && region_hit;
    end

    wsi_count_calc #(.CNT_W(WAIT_W), .VRAM_EXTRA(VRAM_EXTRA)) u_calc (
        .waits (region_waits),
        .vram  (region_vram),
        .eff   (eff_cnt)
    );

    wsi_wait_counter #(.CNT_W(WAIT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bus_granted),
        .start     (any_start),
        .load_val  (hit_start ? eff_cnt : '0),
        .host_rise (host_rise),
        .busy      (busy)
    );

    wsi_window_gen u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bus_granted || (any_start && !region_hit)),
        .start     (hit_start),
        .sync      (region_sync),
        .host_rise (host_rise),
        .ready     (ready_pulse)
    );

    assign wait_n = !busy;

    AST_MISS_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !region_hit) |=> (wait_n && !ready_pulse)); // R5
    AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && region_hit && !bus_granted && region_waits == '0 && !region_vram)
        |=> wait_n); // R3
    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_granted |=> (wait_n && !ready_pulse)); // R6
endmodule

// File: tb/wsi_wait_inserter_test.sv
module wsi_wait_inserter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, host_rise = 1'b0, bus_granted = 1'b0;
    logic region_hit = 1'b0, region_sync = 1'b0, region_vram = 1'b0;
    logic [3:0] region_waits = '0;
    logic wait_n, ready_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected state
    int  m_cnt = 0;
    bit  m_arm = 0;
    bit  m_rdy = 0;

    always #10 clk = ~clk;

    wsi_wait_inserter uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .host_rise(host_rise),
        .bus_granted(bus_granted), .region_hit(region_hit), .region_waits(region_waits),
        .region_sync(region_sync), .region_vram(region_vram),
        .wait_n(wait_n), .ready_pulse(ready_pulse)
    );

    function automatic int exp_count(input int w, input bit v);
        int s;
        s = w + (v ? 2 : 0);
        return (s > 15) ? 15 : s;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (wait_n !== (m_cnt == 0)) begin
            errors++;
            $display("FAIL %s wait_n actual %b expected %b", tag, wait_n, (m_cnt == 0));
        end
        checks++;
        if (ready_pulse !== m_rdy) begin
            errors++;
            $display("FAIL %s ready_pulse actual %b expected %b", tag, ready_pulse, m_rdy);
        end
    endtask

    // drive one clock of inputs at negedge, update model at posedge, check at next negedge
    task automatic step(input string tag, input bit cs, input bit hr, input bit gr,
                        input bit hit, input int w, input bit sy, input bit vr);
        cyc_start = cs; host_rise = hr; bus_granted = gr; region_hit = hit;
        region_waits = 4'(w); region_sync = sy; region_vram = vr;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_arm = 0; m_rdy = 0;
        end else if (gr) begin
            m_cnt = 0; m_arm = 0; m_rdy = 0;
        end else if (cs && hit) begin
            m_cnt = exp_count(w, vr); m_arm = sy; m_rdy = !sy;
        end else if (cs) begin
            m_cnt = 0; m_arm = 0; m_rdy = 0;
        end else begin
            if (hr && m_cnt != 0) m_cnt--;
            m_rdy = m_arm && hr;
            if (hr) m_arm = 0;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input string tag, input int n, input bit hr);
        for (int i = 0; i < n; i++) step(tag, 0, hr, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step("R1", 0, 1, 0, 1, 5, 0, 0);
        step("R1", 1, 1, 0, 1, 5, 0, 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 0, 0);

        // R2 and R7: three waits, no sync
        step("R7", 1, 0, 0, 1, 3, 0, 0);
        idle("R2", 2, 0);
        idle("R2", 3, 1);
        idle("R2", 2, 0);

        // R3: zero count
        step("R3", 1, 0, 0, 1, 0, 0, 0);
        idle("R3", 2, 1);

        // R4: video RAM surcharge and saturation (R10 full field)
        step("R4", 1, 0, 0, 1, 1, 0, 1);
        idle("R4", 4, 1);
        step("R10", 1, 0, 0, 1, 15, 0, 1);
        idle("R10", 16, 1);

        // R5: miss while waiting releases
        step("R5", 1, 0, 0, 1, 6, 0, 0);
        step("R5", 1, 0, 0, 0, 6, 0, 0);
        idle("R5", 2, 0);

        // R8: sync window waits for host rise
        step("R8", 1, 0, 0, 1, 2, 1, 0);
        idle("R8", 3, 0);
        idle("R8", 3, 1);

        // R9: host rise in start clock does not count, reload mid-wait
        step("R9", 1, 1, 0, 1, 2, 1, 0);
        idle("R9", 1, 1);
        step("R9", 1, 0, 0, 1, 4, 0, 0);
        idle("R9", 5, 1);

        // R6: grant clears and blocks starts
        step("R6", 1, 0, 0, 1, 9, 1, 0);
        step("R6", 0, 0, 1, 0, 0, 0, 0);
        step("R6", 1, 1, 1, 1, 9, 0, 0);
        idle("R6", 3, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit cs, hr, gr, hit, sy, vr;
            int w;
            cs  = ($urandom % 8) == 0;
            hr  = ($urandom % 3) == 0;
            gr  = ($urandom % 40) == 0;
            hit = ($urandom % 4) != 0;
            sy  = $urandom % 2;
            vr  = ($urandom % 4) == 0;
            w   = ($urandom % 3 == 0) ? 0 : int'($urandom % 16);
            step("R2", cs, hr, gr, hit, w, sy, vr);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule